// File: doc/BRIEF.md
# Output Driver Impedance Calibration Sequencer

This block is the digital half of an output-driver impedance calibration loop. A replica driver leg is set from a 6-bit trial code, and an analog comparator reports whether the replica is weaker or stronger than the impedance requested by an external reference resistor. The block steps the trial code towards the comparator's answer and holds the live drive-strength code that feeds the real output drivers. The analog front end, the resistor and the driver legs lie outside the block.

After reset the drivers start from the code for 50 ohms. An initial calibration window runs for 1024 cycles, after which a calibrated flag is raised. Background calibration windows then recur every 4096 cycles. A search decision becomes a step only when two successive comparator samples agree, so a loop resting at its target does not dither. The live code takes a new value only on cycles where the output path reports itself idle, so a transfer in progress never sees a change in drive strength. A board strap that ties the reference pin to the I/O supply forces the strongest drive and skips calibration.

Top module: `zcal_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, `drive_code` and `trial_code` both equal 30 (the 50-ohm code) and `cal_done` is 0 (with `strap_min` low).
- R2: The code for an impedance of Z ohms is 80 - Z, where Z is one fifth of the reference resistance. A loop whose comparator target is code T, with T between 10 and 45, settles with `trial_code` equal to T, and `drive_code` follows it on an idle cycle.
- R3: `trial_code` never leaves the range 10 (70 ohms) to 45 (35 ohms). A target outside that range leaves the code stuck at the nearer limit.
- R4: `cal_done` is 0 for the first 1023 cycles after reset is released and 1 from the 1024th rising edge on.
- R5: While `strap_min` is 1, `cal_done` is 1, `drive_code` becomes 63 (all legs on, minimum impedance) at the next rising edge, and `trial_code` does not move.
- R6: Each search step changes `trial_code` by exactly one. Up when `cmp_up` is 1, down when it is 0. A step happens only on an edge where `cmp_up` equals its value at the previous edge, which was also a search edge that made no step. A step clears this history.
- R7: `drive_code` loads the current `trial_code` on a rising edge where `output_idle` is 1 and `strap_min` is 0. On an edge with both low it holds.
- R8: After the initial window, the search is off for 4032 cycles, then on for 64 cycles. This pattern repeats with a period of 4096 cycles. The first background search edge is the 5057th edge after reset release, counting from 1.
- R9: Outside a search window, `trial_code` holds whatever `cmp_up` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_up | input | 1 | Comparator result: 1 means the target needs a higher code than `trial_code` |
| strap_min | input | 1 | Reference pin tied to the I/O supply: force minimum impedance |
| output_idle | input | 1 | Output path idle: live code may change this cycle |
| trial_code | output | 6 | Code applied to the replica leg during the search |
| drive_code | output | 6 | Live drive-strength code for the output drivers |
| cal_done | output | 1 | Initial calibration finished, or strap active |

## Verification
Two things can happen on the same edge: a search step and an idle-gated load of the live code. When both occur together, the live register must take the trial value from before the step. The bench provokes this by holding `output_idle` high or toggling it through both the initial window and the background windows. A cycle-by-cycle reference model, built from cycle counts since reset, judges the result on every clock. A second collision, between the strap and the burst timing, is also covered: the strap is raised and dropped outside the search windows, and it is also held through a reset, where it must keep the code frozen at the default while driving 63.

// File: rtl/zcal_pkg.sv
package zcal_pkg;

    parameter int CODE_W = 6;
    typedef logic [CODE_W-1:0] code_t;

    // code = OHM_OFS - impedance in ohms
    localparam int OHM_OFS = 80;

    function automatic code_t ohm_to_code(input int ohm);
        return code_t'(OHM_OFS - ohm);
    endfunction

    localparam code_t CODE_LO     = ohm_to_code(70);
    localparam code_t CODE_HI     = ohm_to_code(35);
    localparam code_t CODE_DEF    = ohm_to_code(50);
    localparam code_t CODE_STRONG = '1;

    typedef enum logic [1:0] {
        PH_INIT  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_BURST = 2'd2
    } phase_e;

    typedef struct packed {
        logic vld;
        logic up;
    } hist_t;

endpackage

// File: rtl/zcal_timer.sv
module zcal_timer
    import zcal_pkg::*;
#(
    parameter int INIT_CYCLES = 1024,
    parameter int PERIOD      = 4096,
    parameter int BURST       = 64
) (
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);
    localparam int GAP   = PERIOD - BURST;
    localparam int MAXC  = (INIT_CYCLES > PERIOD) ? INIT_CYCLES : PERIOD;
    localparam int CNT_W = $clog2(MAXC) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    phase_e           nxt;

    always_comb begin
        unique case (phase)
            PH_INIT:  begin last = CNT_W'(INIT_CYCLES - 1); nxt = PH_WAIT;  end
            PH_WAIT:  begin last = CNT_W'(GAP - 1);         nxt = PH_BURST; end
            default:  begin last = CNT_W'(BURST - 1);       nxt = PH_WAIT;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_INIT;
            cnt   <= '0;
        end else if (cnt == last) begin
            phase <= nxt;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_init_len_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INIT) |-> (cnt < CNT_W'(INIT_CYCLES)));

    p_burst_len_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BURST) |-> (cnt < CNT_W'(BURST)));

    p_no_return_init_r8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_INIT) |=> (phase != PH_INIT));

endmodule

// File: rtl/zcal_search.sv
module zcal_search
    import zcal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  cmp_up,
    output code_t srch
);
    hist_t hist;
    logic  agree;

    assign agree = hist.vld && (hist.up == cmp_up);

    always_ff @(posedge clk) begin
        if (rst) begin
            srch <= CODE_DEF;
            hist <= '0;
        end else if (!active) begin
            hist.vld <= 1'b0;
        end else if (agree) begin
            hist.vld <= 1'b0;
            if (cmp_up && (srch < CODE_HI))
                srch <= srch + 1'b1;
            else if (!cmp_up && (srch > CODE_LO))
                srch <= srch - 1'b1;
        end else begin
            hist <= '{vld: 1'b1, up: cmp_up};
        end
    end

    p_range_r3: assert property (@(posedge clk) disable iff (rst)
        (srch >= CODE_LO) && (srch <= CODE_HI));

    p_one_lsb_r6: assert property (@(posedge clk) disable iff (rst)
        (srch != $past(srch)) |->
            ((srch == $past(srch) + 1'b1) || (srch == $past(srch) - 1'b1)));

    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(srch));

    p_step_after_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (srch != $past(srch)) |-> $past(hist.vld));

endmodule

// File: rtl/zcal_live.sv
module zcal_live
    import zcal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strap_min,
    input  logic  output_idle,
    input  code_t trial,
    output code_t drive
);
    always_ff @(posedge clk) begin
        if (rst)
            drive <= CODE_DEF;
        else if (strap_min)
            drive <= CODE_STRONG;
        else if (output_idle)
            drive <= trial;
    end

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (!output_idle && !strap_min) |=> $stable(drive));

    p_strap_strong_r5: assert property (@(posedge clk) disable iff (rst)
        strap_min |=> (drive == CODE_STRONG));

endmodule

// File: rtl/zcal_seq.sv
module zcal_seq
    import zcal_pkg::*;
#(
    parameter int INIT_CYCLES = 1024,
    parameter int PERIOD      = 4096,
    parameter int BURST       = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_up,
    input  logic              strap_min,
    input  logic              output_idle,
    output logic [CODE_W-1:0] trial_code,
    output logic [CODE_W-1:0] drive_code,
    output logic              cal_done
);
    phase_e phase;
    logic   active;
    code_t  srch;
    code_t  drive;

    zcal_timer #(
        .INIT_CYCLES (INIT_CYCLES),
        .PERIOD      (PERIOD),
        .BURST       (BURST)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    assign active = (phase != PH_WAIT) && !strap_min;

    zcal_search u_search (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .cmp_up (cmp_up),
        .srch   (srch)
    );

    zcal_live u_live (
        .clk         (clk),
        .rst         (rst),
        .strap_min   (strap_min),
        .output_idle (output_idle),
        .trial       (srch),
        .drive       (drive)
    );

    assign trial_code = srch;
    assign drive_code = drive;
    assign cal_done   = (phase != PH_INIT) || strap_min;

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !strap_min) |=> (cal_done || $rose(strap_min) || $fell(strap_min) || strap_min || cal_done));

    p_strap_done_r5: assert property (@(posedge clk) disable iff (rst)
        strap_min |-> cal_done);

endmodule

// File: tb/zcal_seq_test.sv
module zcal_seq_test;

    localparam int INITC = 1024;
    localparam int PER   = 4096;
    localparam int BUR   = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_up = 1'b0;
    logic       strap_min = 1'b0;
    logic       output_idle = 1'b1;
    logic [5:0] trial_code;
    logic [5:0] drive_code;
    logic       cal_done;

    int total = 0;
    int bad = 0;
    int target = 40;
    bit tog = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int m_cyc = 0;
    int m_s = 30;
    int m_live = 30;
    bit m_h = 1'b0;
    bit m_hv = 1'b0;

    always #5 clk = ~clk;

    zcal_seq uut (
        .clk         (clk),
        .rst         (rst),
        .cmp_up      (cmp_up),
        .strap_min   (strap_min),
        .output_idle (output_idle),
        .trial_code  (trial_code),
        .drive_code  (drive_code),
        .cal_done    (cal_done)
    );

    always @(posedge clk) begin : model
        bit act;
        if (rst) begin
            m_cyc = 0;
            m_s = 30;
            m_live = 30;
            m_hv = 1'b0;
        end else begin
            act = ((m_cyc < INITC) || (((m_cyc - INITC) % PER) >= (PER - BUR))) && !strap_min;
            if (strap_min) m_live = 63;
            else if (output_idle) m_live = m_s;
            if (act) begin
                if (m_hv && (m_h == cmp_up)) begin
                    m_hv = 1'b0;
                    if (cmp_up && m_s < 45) m_s = m_s + 1;
                    else if (!cmp_up && m_s > 10) m_s = m_s - 1;
                end else begin
                    m_h = cmp_up;
                    m_hv = 1'b1;
                end
            end else begin
                m_hv = 1'b0;
            end
            m_cyc = m_cyc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: compare with model at the falling edge, then update comparator
    task automatic tick();
        int exp_done;
        @(negedge clk);
        exp_done = ((m_cyc >= INITC) || strap_min) ? 1 : 0;
        chk(trial_code == 6'(m_s), "R6/R8 trial_code vs model", trial_code, m_s);
        chk(drive_code == 6'(m_live), "R7 drive_code vs model", drive_code, m_live);
        chk(cal_done == exp_done[0], "R4 cal_done vs model", cal_done, exp_done);
        tog = ~tog;
        if (trial_code < 6'(target)) cmp_up = 1'b1;
        else if (trial_code > 6'(target) || target < 0) cmp_up = 1'b0;
        else cmp_up = tog;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_toggle_idle(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            output_idle = ((i % 3) != 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        run(5);
        chk(drive_code == 6'd30, "R1 drive_code in reset", drive_code, 30);
        chk(trial_code == 6'd30, "R1 trial_code in reset", trial_code, 30);
        chk(cal_done == 1'b0, "R1 cal_done in reset", cal_done, 0);
        rst = 1'b0;
        tick();
        chk(drive_code == 6'd30, "R1 drive_code after release", drive_code, 30);

        // initial window, target 40 ohms (code 40), idle high throughout
        run(INITC - 2);
        chk(cal_done == 1'b0, "R4 cal_done before 1024 edges", cal_done, 0);
        tick();
        chk(cal_done == 1'b1, "R4 cal_done at 1024 edges", cal_done, 1);
        chk(trial_code == 6'd40, "R2 settle to 40-ohm code", trial_code, 40);
        chk(drive_code == 6'd40, "R2 drive follows settled code", drive_code, 40);

        // background window, target 70 ohms (code 10), idle low
        target = 10;
        output_idle = 1'b0;
        run(2000);
        chk(trial_code == 6'd40, "R9 frozen outside window", trial_code, 40);
        run(2033);
        chk(trial_code == 6'd40, "R8 first burst edge only records", trial_code, 40);
        tick();
        chk(trial_code == 6'd39, "R8 step on second burst edge", trial_code, 39);
        run(63);
        chk(trial_code == 6'd10, "R2 settle to 70-ohm code", trial_code, 10);
        chk(drive_code == 6'd40, "R7 live holds while busy", drive_code, 40);
        output_idle = 1'b1;
        tick();
        chk(drive_code == 6'd10, "R7 live loads on idle", drive_code, 10);

        // out-of-range target below limit
        target = 3;
        run_toggle_idle(4094);
        chk(trial_code == 6'd10, "R3 clamp at low limit", trial_code, 10);

        // out-of-range target above limit: 64 edges give 32 steps
        target = 60;
        run_toggle_idle(4096);
        chk(trial_code == 6'd42, "R6 32 steps per 64-edge window", trial_code, 42);
        run_toggle_idle(4096);
        chk(trial_code == 6'd45, "R3 clamp at high limit", trial_code, 45);
        output_idle = 1'b1;
        tick();
        chk(drive_code == 6'd45, "R7 live at high limit", drive_code, 45);

        // strap raised in the quiet gap
        strap_min = 1'b1;
        tick();
        chk(drive_code == 6'd63, "R5 strap forces strongest code", drive_code, 63);
        chk(cal_done == 1'b1, "R5 strap asserts done", cal_done, 1);
        run(10);
        chk(trial_code == 6'd45, "R5 trial frozen under strap", trial_code, 45);
        strap_min = 1'b0;
        tick();
        chk(drive_code == 6'd45, "R7 live reloads after strap", drive_code, 45);

        // reset with strap held: calibration skipped
        strap_min = 1'b1;
        target = 20;
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        tick();
        chk(cal_done == 1'b1, "R5 done right after reset", cal_done, 1);
        chk(drive_code == 6'd63, "R5 strongest after reset", drive_code, 63);
        run(100);
        chk(trial_code == 6'd30, "R5 search skipped", trial_code, 30);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule